// File: doc/BRIEF.md
# System Control Register Write Unit

This block holds the privileged control registers of a small 32-bit processor. Software writes them through a move-to-coprocessor port, which carries a register select and a 32-bit data word. Each register applies its own write rule. Some bits are taken from the data. Some bits keep their stored value. All remaining bits are forced to zero. A separate read port returns the stored value of any register at once.

Some writes also act on the rest of the processor. A status write copies the user-mode, error-level and exception-level flags from the data word. A debug write sets or clears the debug-mode flag. An entry-high write that changes the address-space identifier sends a one-cycle flush pulse to the translation logic. A status write that toggles the global interrupt enable re-evaluates the hardware interrupt request, using the pending interrupt lines that the cause logic supplies.

Top module: `sysctl_regbank`

## Requirements
- R1: While reset is active, and after it is released, every register reads 0 and `flag_user`, `flag_erl`, `flag_exl`, `flag_dbg`, `irq_req` and `flush_pulse` are all 0.
- R2: Some registers store only the data bits under a fixed mask and store 0 elsewhere. These are:
  - select 1 and select 2 (entry-low pair), mask 0x3FFFFFFF
  - select 4 (page mask), mask 0x01FFE000
  - select 5 (wired), mask 0x0000000F
  - select 6 (entry high), mask 0xFFFFE0FF
  - select 10 (watch high), mask 0x40FF0FF8
  - select 13 (tag low), mask 0xFFFFFCF6
- R3: Selects 8, 9, 12, 14 and 15 store all 32 data bits unchanged.
- R4: Three registers merge new data with their old value. The result is (old AND keep) OR (data AND take):
  - select 0 (index): keep 0x80000000, take 0x0000000F
  - select 3 (context): keep 0xFF800000, take 0x007FFFF0
  - select 11 (debug): keep 0x8C03FC1F, take 0x13300120
- R5: The flush pulse depends on bits 7:0 of a write to select 6. If those bits differ from the stored bits 7:0, `flush_pulse` is 1 for exactly the cycle after the write edge. Otherwise `flush_pulse` stays 0.
- R6: A write to select 7 (status) stores the data under mask 0xFA78FF01. On the same edge, `flag_user`, `flag_erl` and `flag_exl` take data bits 4, 2 and 1.
- R7: `irq_req` is set by a status write only when all of these hold:
  - data bit 0 (interrupt enable) is 1 and the stored bit 0 is 0
  - data bits 1 and 2 are both 0
  - `flag_dbg` is 0
  - (data[15:8] AND `irq_pending`) is nonzero
- R8: A status write with data bit 0 equal to 0 while the stored bit 0 is 1 clears `irq_req`. Every other write, and every cycle without a write, leaves `irq_req` unchanged.
- R9: A write to select 11 sets `flag_dbg` to data bit 30.
- R10: A write to select 16 or above changes no register and no flag. A read of select 16 or above returns 0.
- R11: A register changes only on a rising clock edge with `wr_en` high. `rd_data` follows `rd_sel` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the move-to-coprocessor port |
| wr_sel | input | 5 | Register select for the write |
| wr_data | input | 32 | Write data word |
| rd_sel | input | 5 | Register select for the read |
| rd_data | output | 32 | Stored value of the selected register, 0 for unknown selects |
| irq_pending | input | 8 | Pending interrupt lines from the cause logic |
| irq_req | output | 1 | Hardware interrupt request |
| flush_pulse | output | 1 | One-cycle translation-flush request |
| flag_user | output | 1 | User-mode flag |
| flag_erl | output | 1 | Error-level flag |
| flag_exl | output | 1 | Exception-level flag |
| flag_dbg | output | 1 | Debug-mode flag |

## Verification
Two results can land in the same cycle. One is the flush pulse from an entry-high write. The other is the interrupt request raised by the status write issued right after it. The bench drives an identifier-changing entry-high write and then, on the very next cycle, a status write that enables interrupts with a pending line unmasked. In the cycle after that status write, the bench checks that the pulse has fallen and the request has risen, each against its own model. The bench also checks that a debug-mode flag set earlier suppresses the rise, and that an exception-level bit in the same status word suppresses it too.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW       = 32;
  localparam int SEL_W    = 5;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int ASID_W   = 8;

  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_UM  = 4;
  localparam int ST_IM_LO = 8;
  localparam int DBG_DM = 30;

  typedef enum logic [SEL_W-1:0] {
    SEL_INDEX   = 5'd0,  SEL_ELO0   = 5'd1,  SEL_ELO1   = 5'd2,  SEL_CTX    = 5'd3,
    SEL_PGMASK  = 5'd4,  SEL_WIRED  = 5'd5,  SEL_EHI    = 5'd6,  SEL_STATUS = 5'd7,
    SEL_EPC     = 5'd8,  SEL_WLO    = 5'd9,  SEL_WHI    = 5'd10, SEL_DEBUG  = 5'd11,
    SEL_DPC     = 5'd12, SEL_TAGLO  = 5'd13, SEL_ERRPC  = 5'd14, SEL_DSAVE  = 5'd15
  } sel_e;

  function automatic logic [DW-1:0] keep_mask(input int idx);
    case (idx)
      0:       return 32'h8000_0000;
      3:       return 32'hFF80_0000;
      11:      return 32'h8C03_FC1F;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] take_mask(input int idx);
    case (idx)
      0:       return 32'h0000_000F;
      1, 2:    return 32'h3FFF_FFFF;
      3:       return 32'h007F_FFF0;
      4:       return 32'h01FF_E000;
      5:       return 32'h0000_000F;
      6:       return 32'hFFFF_E0FF;
      7:       return 32'hFA78_FF01;
      10:      return 32'h40FF_0FF8;
      11:      return 32'h1330_0120;
      13:      return 32'hFFFF_FCF6;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysctl_field_reg.sv
module sysctl_field_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] KEEP = '0,
  parameter logic [W-1:0] TAKE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (we) q_next = (q & KEEP) | (wdata & TAKE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/sysctl_side_fx.sv
module sysctl_side_fx
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic              dbg_we,
  input  logic              ehi_we,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     status_q,
  input  logic [DW-1:0]     entryhi_q,
  input  logic [7:0]        irq_pending,
  output logic              irq_req,
  output logic              flush_pulse,
  output logic              flag_user,
  output logic              flag_erl,
  output logic              flag_exl,
  output logic              flag_dbg
);
  logic irq_n, flush_n, um_n, erl_n, exl_n, dm_n;
  logic ie_rise, ie_fall, im_hit;

  assign ie_rise = wdata[ST_IE] & ~status_q[ST_IE];
  assign ie_fall = ~wdata[ST_IE] & status_q[ST_IE];
  assign im_hit  = |(wdata[ST_IM_LO +: 8] & irq_pending);

  always_comb begin
    irq_n   = irq_req;
    um_n    = flag_user;
    erl_n   = flag_erl;
    exl_n   = flag_exl;
    dm_n    = flag_dbg;
    flush_n = ehi_we && (wdata[ASID_W-1:0] != entryhi_q[ASID_W-1:0]);
    if (st_we) begin
      um_n  = wdata[ST_UM];
      erl_n = wdata[ST_ERL];
      exl_n = wdata[ST_EXL];
      if (ie_rise && !wdata[ST_EXL] && !wdata[ST_ERL] && !flag_dbg && im_hit)
        irq_n = 1'b1;
      else if (ie_fall)
        irq_n = 1'b0;
    end
    if (dbg_we) dm_n = wdata[DBG_DM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req     <= 1'b0;
      flush_pulse <= 1'b0;
      flag_user   <= 1'b0;
      flag_erl    <= 1'b0;
      flag_exl    <= 1'b0;
      flag_dbg    <= 1'b0;
    end else begin
      irq_req     <= irq_n;
      flush_pulse <= flush_n;
      flag_user   <= um_n;
      flag_erl    <= erl_n;
      flag_exl    <= exl_n;
      flag_dbg    <= dm_n;
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic [7:0]       irq_pending,
  output logic             irq_req,
  output logic             flush_pulse,
  output logic             flag_user,
  output logic             flag_erl,
  output logic             flag_exl,
  output logic             flag_dbg
);
  logic                          rst_sync_n;
  logic [NUM_REGS-1:0]           we_vec;
  logic [NUM_REGS-1:0][DW-1:0]   regs_q;

  sysctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign we_vec[g] = wr_en && (wr_sel == SEL_W'(g));
    sysctl_field_reg #(
      .W(DW), .KEEP(keep_mask(g)), .TAKE(take_mask(g))
    ) u_fld (
      .clk(clk), .rst_n(rst_sync_n), .we(we_vec[g]),
      .wdata(wr_data), .q(regs_q[g])
    );
  end

  sysctl_side_fx u_fx (
    .clk(clk), .rst_n(rst_sync_n),
    .st_we(we_vec[SEL_STATUS]), .dbg_we(we_vec[SEL_DEBUG]), .ehi_we(we_vec[SEL_EHI]),
    .wdata(wr_data), .status_q(regs_q[SEL_STATUS]), .entryhi_q(regs_q[SEL_EHI]),
    .irq_pending(irq_pending), .irq_req(irq_req), .flush_pulse(flush_pulse),
    .flag_user(flag_user), .flag_erl(flag_erl), .flag_exl(flag_exl), .flag_dbg(flag_dbg)
  );

  always_comb begin
    rd_data = '0;
    if (rd_sel < SEL_W'(NUM_REGS)) rd_data = regs_q[rd_sel[IDX_W-1:0]];
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
(
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        wr_en,
  input logic [SEL_W-1:0]            wr_sel,
  input logic [DW-1:0]               wr_data,
  input logic [SEL_W-1:0]            rd_sel,
  input logic [DW-1:0]               rd_data,
  input logic [7:0]                  irq_pending,
  input logic [NUM_REGS-1:0][DW-1:0] regs_q,
  input logic                        irq_req,
  input logic                        flush_pulse,
  input logic                        flag_user,
  input logic                        flag_dbg
);
  logic ehi_chg, st_wr;
  assign ehi_chg = wr_en && wr_sel == SEL_EHI && wr_data[7:0] != regs_q[SEL_EHI][7:0];
  assign st_wr   = wr_en && wr_sel == SEL_STATUS;

  a_r5_flush_on_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ehi_chg |=> flush_pulse);
  a_r5_flush_only_on_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ehi_chg |=> !flush_pulse);
  a_r6_user_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_wr |=> flag_user == $past(wr_data[ST_UM]));
  a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_wr && wr_data[0] && !regs_q[SEL_STATUS][0] && !wr_data[1] && !wr_data[2] &&
     !flag_dbg && |(wr_data[15:8] & irq_pending)) |=> irq_req);
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_wr && !wr_data[0] && regs_q[SEL_STATUS][0]) |=> !irq_req);
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !st_wr |=> $stable(irq_req));
  a_r9_dbg_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel == SEL_DEBUG) |=> flag_dbg == $past(wr_data[DBG_DM]));
  a_r10_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_sel >= SEL_W'(NUM_REGS)) |-> rd_data == '0);
  a_r11_no_write_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(regs_q));
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_pending(irq_pending),
  .regs_q(regs_q), .irq_req(irq_req), .flush_pulse(flush_pulse),
  .flag_user(flag_user), .flag_dbg(flag_dbg)
);

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq_pending = '0;
  logic        irq_req, flush_pulse, flag_user, flag_erl, flag_exl, flag_dbg;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic [31:0] model [16];
  logic        m_irq = 0, m_dbg = 0, m_um = 0, m_erl = 0, m_exl = 0, m_flush = 0;

  always #2 clk = ~clk;

  sysctl_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pending(irq_pending), .irq_req(irq_req),
    .flush_pulse(flush_pulse), .flag_user(flag_user), .flag_erl(flag_erl),
    .flag_exl(flag_exl), .flag_dbg(flag_dbg)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [31:0] keep_of(input int s);
    if (s == 0)  return 32'h8000_0000;
    if (s == 3)  return 32'hFF80_0000;
    if (s == 11) return 32'h8C03_FC1F;
    return 32'h0;
  endfunction

  function automatic logic [31:0] take_of(input int s);
    case (s)
      0: return 32'h0000_000F;  1, 2: return 32'h3FFF_FFFF;
      3: return 32'h007F_FFF0;  4: return 32'h01FF_E000;
      5: return 32'h0000_000F;  6: return 32'hFFFF_E0FF;
      7: return 32'hFA78_FF01;  10: return 32'h40FF_0FF8;
      11: return 32'h1330_0120; 13: return 32'hFFFF_FCF6;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Model update, then one write cycle; outputs are sampled at the following negedge.
  task automatic do_write(input int s, input logic [31:0] d);
    m_flush = 0;
    if (s < 16) begin
      if (s == 6)  m_flush = (d[7:0] != model[6][7:0]);
      if (s == 7) begin
        if (d[0] && !model[7][0] && !d[1] && !d[2] && !m_dbg && |(d[15:8] & irq_pending))
          m_irq = 1;
        else if (!d[0] && model[7][0])
          m_irq = 0;
        m_um = d[4]; m_erl = d[2]; m_exl = d[1];
      end
      if (s == 11) m_dbg = d[30];
      model[s] = (model[s] & keep_of(s)) | (d & take_of(s));
    end
    wr_en = 1; wr_sel = 5'(s); wr_data = d; rd_sel = 5'(s);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_flags(input string req);
    chk(req, {26'd0, flush_pulse, irq_req, flag_user, flag_erl, flag_exl, flag_dbg},
        {26'd0, m_flush, m_irq, m_um, m_erl, m_exl, m_dbg});
  endtask

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h5A5A_5A5A; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h0000_0000; pats[4] = 32'h1357_9BDF;
    for (int i = 0; i < 16; i++) model[i] = '0;

    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is held
    chk("R1 irq/flags in reset", {26'd0, flush_pulse, irq_req, flag_user, flag_erl, flag_exl, flag_dbg}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 32; s++) begin
      rd_sel = 5'(s);
      #1 chk("R1 register zero after reset", rd_data, 32'd0);
    end

    // R2 R3 R4 R10 R11: sweep every select with several patterns
    for (int p = 0; p < 5; p++) begin
      for (int s = 0; s < 32; s++) begin
        do_write(s, pats[p] ^ (32'h0101_0101 * s));
        if (s < 16) chk($sformatf("R2/R3/R4 sel %0d readback", s), rd_data, model[s]);
        else        chk("R10 unknown select reads zero", rd_data, 32'd0);
        chk_flags("R5/R6/R9 side effects during sweep");
        // R11: no write this cycle, value stays
        @(negedge clk);
        chk("R11 hold without wr_en", rd_data, (s < 16) ? model[s] : 32'd0);
      end
      for (int s = 0; s < 16; s++) begin
        rd_sel = 5'(s);
        #1 chk("R10 unknown writes disturb nothing", rd_data, model[s]);
      end
    end

    // R5: same identifier gives no pulse, then the pulse lasts one cycle only
    do_write(6, 32'h0000_20C3); chk_flags("R5 pulse on change");
    do_write(6, 32'h1234_40C3); chk_flags("R5 no pulse on same id");
    do_write(6, 32'h0000_0011); chk_flags("R5 pulse on change");
    @(negedge clk); m_flush = 0; chk_flags("R5 pulse is one cycle");

    // R7 R8 R9: interrupt request
    irq_pending = 8'h01;
    do_write(11, 32'h0); do_write(7, 32'h0000_0100);
    do_write(7, 32'h0000_0101); chk_flags("R7 rise raises request");
    do_write(7, 32'h0000_0F01); chk_flags("R8 no toggle keeps request");
    do_write(7, 32'h0000_0100); chk_flags("R8 fall clears request");
    do_write(7, 32'h0000_0103); chk_flags("R7 exception level blocks");
    do_write(7, 32'h0000_0100);
    do_write(7, 32'h0000_0105); chk_flags("R7 error level blocks");
    do_write(7, 32'h0000_0100);
    do_write(7, 32'h0000_0201); chk_flags("R7 masked line blocks");
    do_write(7, 32'h0000_0100);
    do_write(11, 32'h4000_0000); chk_flags("R9 debug flag set");
    do_write(7, 32'h0000_0101); chk_flags("R7 debug mode blocks");
    do_write(7, 32'h0000_0100);
    do_write(11, 32'h0000_0000); chk_flags("R9 debug flag clear");
    // same-cycle case: flush pulse and request rise back to back
    do_write(6, 32'h0000_0077); chk_flags("R5 pulse before status write");
    m_flush = 0;
    do_write(7, 32'h0000_0111); chk_flags("R5/R7 pulse ends and request rises");
    irq_pending = 8'h00; @(negedge clk);
    chk_flags("R8 pending drop does not clear request");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule